// File: doc/BRIEF.md
# Infrared Pulse-Width Capture Receiver

This block samples an already-demodulated infrared line and turns the waveform into raw timing data for software. Each symbol is one low phase followed by one high phase. The block measures both phases in units of ten base ticks. A base tick is one microsecond when the prescaler is programmed to the input clock frequency in MHz minus one. Each pair is stored as one 32-bit word in a 64-entry symbol FIFO, and software reads the FIFO through a small 32-bit register bus. A symbol whose total length reaches a programmable maximum is taken to end a frame. All protocol decoding is left to software.

Two state machines drive the block. The control machine has four states: `CTL_OFF` (idle), `CTL_INIT` (busy, FIFO and status being cleared), `CTL_READY` (enabled, waiting for start) and `CTL_RUN` (capturing). Its transitions are:
- Off to init: a write of 1 to the enable register.
- Init to ready: the init counter expires.
- Ready to run: any write to the start register.
- Any state to off: a write of 0 to the enable register.

The capture machine has three states: `CAP_IDLE` (line high, waiting), `CAP_LOW` (timing the low phase) and `CAP_HIGH` (timing the high phase). Its transitions are:
- Idle to low: a falling edge while running.
- Low to high: a rising edge.
- High to low: a falling edge, which stores the symbol.
- High to idle: the low plus high total reaches the maximum, which stores the symbol and flags a timeout.
- Any state to idle: capture is not running.

Three interrupt sources share one output:
- receive level reached
- frame timeout
- FIFO overflow

Each source can be masked, and each is cleared by writing 1 to its clear bit.

Top module: `ir_pulse_rx`

## Requirements
- R1: After reset, enable, busy, symbol count and status all read 0. The mask register reads 3'b111 and `irq_o` is 0.
- R2: Writing 1 to enable (offset 0x00, bit 0) while off puts the block in init for INIT_CYCLES clocks. During init, busy (offset 0x1C, bit 0) reads 1, the FIFO is emptied and all status bits are cleared. Afterwards busy reads 0 and enable reads 1.
- R3: Input edges produce no symbols until a write to start (offset 0x34) arrives while the block is enabled and not busy. A start write while off is ignored.
- R4: A stored symbol holds the low duration in bits 15:0 and the high duration in bits 31:16. With prescaler P (config bits 6:0), a phase lasting L clocks measures floor((L-1)/(10*(P+1))) units.
- R5: In the only supported format (config bits 15:14 = 0), a symbol runs from a falling edge to the next falling edge. It is stored when that second falling edge arrives.
- R6: When low plus high reaches the maximum width (config bits 31:16) during the high phase, the symbol is stored with the high count reached at that point. The timeout status is set and capture waits for the next falling edge.
- R7: A read of the count register (0x20) returns the number of stored symbols. Each read of the data register (0x24) returns the oldest symbol and removes it. A data read when the FIFO is empty returns 0 and changes nothing.
- R8: The receive status is set in every cycle in which the symbol count is at least the level field (config bits 13:8) plus one.
- R9: The FIFO holds 64 symbols. A symbol that completes while the FIFO is full is discarded and sets the overflow status. The stored symbols are left intact.
- R10: The status register (0x2C) shows raw receive, timeout and overflow at bits 24, 25 and 26. It shows the same bits gated by their enables at bits 8, 9 and 10. Writing 1 to bit 16, 17 or 18 of the clear register (0x30) clears the matching status bit.
- R11: `irq_o` is high exactly when some raw status bit is set whose mask bit is 0. In the mask register (0x28), bit 0 is receive, bit 1 is timeout and bit 2 is overflow, and 0 means enabled.
- R12: Writing 0 to enable stops capture at once. Later edges store nothing, and the FIFO keeps its contents until the next init.
- R13: The config register (0x04) reads back the last value written to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe; data appears the next cycle |
| bus_addr_i | input | 8 | Register byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| ir_i | input | 1 | Demodulated infrared line, idle high |
| irq_o | output | 1 | Interrupt request |

## Verification
Measurement is tried with three stimulus patterns:
- Chains of random low/high pairs, which tell edge-ended symbols apart from the timeout-ended final symbol.
- Single bursts that sit high until timeout, which separate the count threshold from the timeout flag.
- A run of 65 short symbols, which shows that overflow drops only the newest symbol and keeps the older entries in order.

A burst captured at a prescaler of 4 shows that the unit scales with the prescaler rather than with the clock alone. Edges sent before start and after disable show that gating works.

// File: rtl/irc_pkg.sv
`timescale 1ns/1ps
package irc_pkg;
    typedef enum logic [1:0] {
        CTL_OFF,
        CTL_INIT,
        CTL_READY,
        CTL_RUN
    } ctl_state_t;

    typedef enum logic [1:0] {
        CAP_IDLE,
        CAP_LOW,
        CAP_HIGH
    } cap_state_t;

    localparam logic [7:0] OFS_ENABLE = 8'h00;
    localparam logic [7:0] OFS_CONFIG = 8'h04;
    localparam logic [7:0] OFS_BUSY   = 8'h1C;
    localparam logic [7:0] OFS_COUNT  = 8'h20;
    localparam logic [7:0] OFS_DATA   = 8'h24;
    localparam logic [7:0] OFS_MASK   = 8'h28;
    localparam logic [7:0] OFS_STATUS = 8'h2C;
    localparam logic [7:0] OFS_CLEAR  = 8'h30;
    localparam logic [7:0] OFS_START  = 8'h34;

    localparam int SRC_N = 3;
endpackage

// File: rtl/irc_timebase.sv
`timescale 1ns/1ps
module irc_timebase #(
    parameter int PRE_W   = 7,
    parameter int SUB_DIV = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic [PRE_W-1:0] presc_i,
    output logic             unit_o
);
    localparam int SUB_W = $clog2(SUB_DIV);

    logic [PRE_W-1:0] pre_q;
    logic [SUB_W-1:0] sub_q;
    logic             base_tick;

    assign base_tick = (pre_q >= presc_i) && !restart_i;
    assign unit_o    = base_tick && (sub_q == SUB_W'(SUB_DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            sub_q <= '0;
        end else if (restart_i) begin
            pre_q <= '0;
            sub_q <= '0;
        end else if (base_tick) begin
            pre_q <= '0;
            sub_q <= (sub_q == SUB_W'(SUB_DIV - 1)) ? '0 : sub_q + 1'b1;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/irc_capture.sv
`timescale 1ns/1ps
module irc_capture
    import irc_pkg::*;
#(
    parameter int DUR_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_i,
    input  logic               line_i,
    input  logic               unit_i,
    input  logic [DUR_W-1:0]   maxw_i,
    output logic               restart_o,
    output logic               push_o,
    output logic               tmo_o,
    output logic [2*DUR_W-1:0] sym_o
);
    cap_state_t       st_q, st_n;
    logic [DUR_W-1:0] low_q, high_q;
    logic             line_d;
    logic             fall, rise, reach;
    logic [DUR_W:0]   total;

    assign fall  = line_d && !line_i;
    assign rise  = !line_d && line_i;
    assign total = {1'b0, low_q} + {1'b0, high_q};
    assign reach = total >= {1'b0, maxw_i};
    assign sym_o = {high_q, low_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= CAP_IDLE;
            line_d <= 1'b1;
        end else begin
            st_q   <= st_n;
            line_d <= line_i;
        end
    end

    always_comb begin
        st_n      = st_q;
        restart_o = 1'b0;
        push_o    = 1'b0;
        tmo_o     = 1'b0;
        unique case (st_q)
            CAP_IDLE: begin
                if (fall) begin
                    st_n      = CAP_LOW;
                    restart_o = 1'b1;
                end
            end
            CAP_LOW: begin
                if (rise) begin
                    st_n      = CAP_HIGH;
                    restart_o = 1'b1;
                end
            end
            CAP_HIGH: begin
                if (reach) begin
                    st_n   = CAP_IDLE;
                    push_o = 1'b1;
                    tmo_o  = 1'b1;
                end else if (fall) begin
                    st_n      = CAP_LOW;
                    push_o    = 1'b1;
                    restart_o = 1'b1;
                end
            end
            default: st_n = CAP_IDLE;
        endcase
        if (!run_i) begin
            st_n      = CAP_IDLE;
            restart_o = 1'b0;
            push_o    = 1'b0;
            tmo_o     = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_q  <= '0;
            high_q <= '0;
        end else begin
            if (st_n == CAP_LOW && st_q != CAP_LOW)
                low_q <= '0;
            else if (st_q == CAP_LOW && unit_i && low_q != '1)
                low_q <= low_q + 1'b1;
            if (st_n == CAP_HIGH && st_q != CAP_HIGH)
                high_q <= '0;
            else if (st_q == CAP_HIGH && unit_i && high_q != '1)
                high_q <= high_q + 1'b1;
        end
    end

    // R6
    cap_tmo_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_o |=> (st_q == CAP_IDLE));
endmodule

// File: rtl/irc_fifo.sv
`timescale 1ns/1ps
module irc_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush_i,
    input  logic                       push_i,
    input  logic                       pop_i,
    input  logic [W-1:0]               din_i,
    output logic [W-1:0]               dout_o,
    output logic [$clog2(DEPTH+1)-1:0] count_o,
    output logic                       drop_o
);
    localparam int AW    = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CNT_W-1:0] cnt_q;
    logic             pop_ok, push_ok, full;

    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign pop_ok  = pop_i && (cnt_q != '0);
    assign push_ok = push_i && (!full || pop_ok);
    assign drop_o  = push_i && !push_ok;
    assign dout_o  = mem[rd_ptr];
    assign count_o = cnt_q;

    always_ff @(posedge clk) begin
        if (push_ok && !flush_i)
            mem[wr_ptr] <= din_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else if (flush_i) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (push_ok)
                wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            if (push_ok && !pop_ok)
                cnt_q <= cnt_q + 1'b1;
            else if (pop_ok && !push_ok)
                cnt_q <= cnt_q - 1'b1;
        end
    end

    // R9
    fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH));

    // R9
    fifo_full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push_i && !pop_i && !flush_i) |=> (cnt_q == CNT_W'(DEPTH)));
endmodule

// File: rtl/ir_pulse_rx.sv
`timescale 1ns/1ps
module ir_pulse_rx
    import irc_pkg::*;
#(
    parameter int FIFO_DEPTH  = 64,
    parameter int INIT_CYCLES = 16,
    parameter int DUR_W       = 16,
    parameter int PRE_W       = 7,
    parameter int UNIT_TICKS  = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr_i,
    input  logic [7:0]  bus_addr_i,
    input  logic [31:0] bus_wdata_i,
    input  logic        bus_rd_i,
    output logic [31:0] bus_rdata_o,
    input  logic        ir_i,
    output logic        irq_o
);
    localparam int CNT_W  = $clog2(FIFO_DEPTH + 1);
    localparam int INIT_W = $clog2(INIT_CYCLES + 1);
    localparam int SYM_W  = 2 * DUR_W;

    ctl_state_t       ctl_q, ctl_n;
    logic [INIT_W-1:0] init_cnt;
    logic [31:0]      cfg_q;
    logic [SRC_N-1:0] mask_q, sts_q, sts_set, sts_clr;
    logic [1:0]       sync_q;

    logic             en_wr, start_wr, clr_wr, pop;
    logic             run, busy, flush;
    logic             unit, restart, push, tmo, drop;
    logic [SYM_W-1:0] sym, fifo_dout;
    logic [CNT_W-1:0] fifo_cnt;
    logic [5:0]       lvl;

    assign en_wr    = bus_wr_i && (bus_addr_i == OFS_ENABLE);
    assign start_wr = bus_wr_i && (bus_addr_i == OFS_START);
    assign clr_wr   = bus_wr_i && (bus_addr_i == OFS_CLEAR);
    assign pop      = bus_rd_i && (bus_addr_i == OFS_DATA);
    assign run      = (ctl_q == CTL_RUN);
    assign busy     = (ctl_q == CTL_INIT);
    assign flush    = busy;
    assign lvl      = cfg_q[13:8];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], ir_i};
    end

    irc_timebase #(.PRE_W(PRE_W), .SUB_DIV(UNIT_TICKS)) tb_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .presc_i   (cfg_q[PRE_W-1:0]),
        .unit_o    (unit)
    );

    irc_capture #(.DUR_W(DUR_W)) cap_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run),
        .line_i    (sync_q[1]),
        .unit_i    (unit),
        .maxw_i    (cfg_q[31:16]),
        .restart_o (restart),
        .push_o    (push),
        .tmo_o     (tmo),
        .sym_o     (sym)
    );

    irc_fifo #(.W(SYM_W), .DEPTH(FIFO_DEPTH)) fifo_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush_i (flush),
        .push_i  (push),
        .pop_i   (pop),
        .din_i   (sym),
        .dout_o  (fifo_dout),
        .count_o (fifo_cnt),
        .drop_o  (drop)
    );

    // control state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_OFF;
        else        ctl_q <= ctl_n;
    end

    always_comb begin
        ctl_n = ctl_q;
        unique case (ctl_q)
            CTL_OFF:   if (en_wr && bus_wdata_i[0]) ctl_n = CTL_INIT;
            CTL_INIT:  if (init_cnt == '0) ctl_n = CTL_READY;
            CTL_READY: if (start_wr) ctl_n = CTL_RUN;
            CTL_RUN:   ctl_n = CTL_RUN;
            default:   ctl_n = CTL_OFF;
        endcase
        if (en_wr && !bus_wdata_i[0])
            ctl_n = CTL_OFF;
    end

    // registers and status driven from the control state
    assign sts_set = {drop, tmo, fifo_cnt >= (CNT_W'(lvl) + CNT_W'(1))};
    assign sts_clr = clr_wr ? bus_wdata_i[16 +: SRC_N] : '0;
    assign irq_o   = |(sts_q & ~mask_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            init_cnt <= '0;
            cfg_q    <= '0;
            mask_q   <= '1;
            sts_q    <= '0;
        end else begin
            if (ctl_q != CTL_INIT && ctl_n == CTL_INIT)
                init_cnt <= INIT_W'(INIT_CYCLES - 1);
            else if (ctl_q == CTL_INIT && init_cnt != '0)
                init_cnt <= init_cnt - 1'b1;
            if (bus_wr_i && bus_addr_i == OFS_CONFIG)
                cfg_q <= bus_wdata_i;
            if (bus_wr_i && bus_addr_i == OFS_MASK)
                mask_q <= bus_wdata_i[SRC_N-1:0];
            if (ctl_q == CTL_INIT)
                sts_q <= '0;
            else
                sts_q <= (sts_q & ~sts_clr) | sts_set;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata_o <= '0;
        end else if (bus_rd_i) begin
            case (bus_addr_i)
                OFS_ENABLE: bus_rdata_o <= {31'b0, ctl_q != CTL_OFF};
                OFS_CONFIG: bus_rdata_o <= cfg_q;
                OFS_BUSY:   bus_rdata_o <= {31'b0, busy};
                OFS_COUNT:  bus_rdata_o <= 32'(fifo_cnt);
                OFS_DATA:   bus_rdata_o <= (fifo_cnt != '0) ? fifo_dout : '0;
                OFS_MASK:   bus_rdata_o <= 32'(mask_q);
                OFS_STATUS: bus_rdata_o <= {5'b0, sts_q, 13'b0, sts_q & ~mask_q, 8'b0};
                default:    bus_rdata_o <= '0;
            endcase
        end
    end

    // R3
    run_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_q == CTL_RUN) |-> $past(start_wr));

    // R10
    tmo_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && bus_wdata_i[17] && !tmo && ctl_q != CTL_INIT) |=> !sts_q[1]);

    // R2
    busy_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> $past(ctl_q == CTL_OFF || ctl_q == CTL_INIT));
endmodule

// File: tb/ir_pulse_rx_tb_top.sv
`timescale 1ns/1ps
module ir_pulse_rx_tb_top;
    localparam int MAXW = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        ir = 1'b1;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;
    int unit_clk = 10;
    logic [31:0] exp_a [0:79];
    int n_exp = 0;

    always #10 clk = ~clk;

    ir_pulse_rx dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr_i    (wr),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rd_i    (rd),
        .bus_rdata_o (rdata),
        .ir_i        (ir),
        .irq_o       (irq)
    );

    function automatic logic [31:0] pack_sym(int lu, int hu);
        return {16'(hu), 16'(lu)};
    endfunction

    function automatic logic [31:0] make_cfg(int maxw, int lvl, int presc);
        return {16'(maxw), 2'b00, 6'(lvl), 1'b1, 7'(presc)};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        rd = 1'b1; addr = a;
        @(negedge clk);
        rd = 1'b0;
        d = rdata;
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // symbol closed by the next falling edge
    task automatic send_sym(input int lu, input int hu);
        @(negedge clk); ir = 1'b0;
        wait_clk(lu * unit_clk + unit_clk / 2);
        ir = 1'b1;
        wait_clk(hu * unit_clk + unit_clk / 2);
    endtask

    // symbol closed by the maximum width
    task automatic burst(input int lu);
        @(negedge clk); ir = 1'b0;
        wait_clk(lu * unit_clk + unit_clk / 2);
        ir = 1'b1;
        wait_clk((MAXW + 2) * unit_clk);
    endtask

    task automatic drain_check(input string req);
        logic [31:0] v;
        for (int i = 0; i < n_exp; i++) begin
            bus_read(8'h24, v);
            check(req, v, exp_a[i]);
        end
        n_exp = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++; n_chk++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int seed_dummy;
        int lu, hu;
        seed_dummy = $urandom(32'd1234);

        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(2);

        // R1 reset state
        bus_read(8'h00, v); check("R1 enable", v, 32'd0);
        bus_read(8'h1C, v); check("R1 busy", v, 32'd0);
        bus_read(8'h20, v); check("R1 count", v, 32'd0);
        bus_read(8'h2C, v); check("R1 status", v, 32'd0);
        bus_read(8'h28, v); check("R1 mask", v, 32'd7);
        check("R1 irq", {31'b0, irq}, 32'd0);

        // R13 config readback
        bus_write(8'h04, make_cfg(MAXW, 2, 0));
        bus_read(8'h04, v); check("R13 config", v, make_cfg(MAXW, 2, 0));

        // R3 start while off ignored
        bus_write(8'h34, 32'd1);
        burst(3);
        bus_read(8'h20, v); check("R3 off count", v, 32'd0);

        // R2 init and busy
        bus_write(8'h00, 32'd1);
        bus_read(8'h1C, v); check("R2 busy during init", v, 32'd1);
        wait_clk(25);
        bus_read(8'h1C, v); check("R2 busy after init", v, 32'd0);
        bus_read(8'h00, v); check("R2 enable", v, 32'd1);

        // R3 edges before start ignored
        burst(3);
        bus_read(8'h20, v); check("R3 ready count", v, 32'd0);
        bus_write(8'h34, 32'd0);

        // R4 R5 R6 random chain
        for (int i = 0; i < 5; i++) begin
            lu = 1 + int'($urandom % 8);
            hu = 1 + int'($urandom % 8);
            send_sym(lu, hu);
            exp_a[n_exp] = pack_sym(lu, hu); n_exp++;
        end
        lu = 1 + int'($urandom % 8);
        burst(lu);
        exp_a[n_exp] = pack_sym(lu, MAXW - lu); n_exp++;
        bus_read(8'h20, v); check("R7 count", v, 32'd6);
        bus_read(8'h2C, v); check("R10 raw status", v, 32'h0300_0000);
        check("R11 irq all masked", {31'b0, irq}, 32'd0);
        bus_write(8'h28, 32'd5);
        check("R11 irq timeout enabled", {31'b0, irq}, 32'd1);
        bus_read(8'h2C, v); check("R10 masked status", v, 32'h0300_0200);
        bus_write(8'h30, 32'h0002_0000);
        check("R11 irq after clear", {31'b0, irq}, 32'd0);
        bus_read(8'h2C, v); check("R10 after clear", v, 32'h0100_0000);
        drain_check("R4/R5/R6 chain");
        bus_read(8'h24, v); check("R7 empty data", v, 32'd0);
        bus_read(8'h20, v); check("R7 empty count", v, 32'd0);
        bus_write(8'h30, 32'h0001_0000);
        bus_read(8'h2C, v); check("R8 rcv cleared", v, 32'd0);

        // R8 threshold at level field 2 plus one
        burst(2); exp_a[n_exp] = pack_sym(2, MAXW - 2); n_exp++;
        burst(4); exp_a[n_exp] = pack_sym(4, MAXW - 4); n_exp++;
        bus_read(8'h2C, v); check("R8 below level", {31'b0, v[24]}, 32'd0);
        burst(5); exp_a[n_exp] = pack_sym(5, MAXW - 5); n_exp++;
        bus_read(8'h2C, v); check("R8 at level", {31'b0, v[24]}, 32'd1);
        drain_check("R6 bursts");
        bus_write(8'h30, 32'h0007_0000);

        // R9 overflow
        bus_write(8'h28, 32'd3);
        for (int i = 0; i < 64; i++) begin
            send_sym(1 + (i % 3), 1 + (i % 2));
            exp_a[n_exp] = pack_sym(1 + (i % 3), 1 + (i % 2)); n_exp++;
        end
        burst(2);
        bus_read(8'h20, v); check("R9 count full", v, 32'd64);
        bus_read(8'h2C, v); check("R9 overflow raw", {31'b0, v[26]}, 32'd1);
        check("R11 irq overflow", {31'b0, irq}, 32'd1);
        drain_check("R9 kept entries");
        bus_write(8'h30, 32'h0004_0000);
        bus_read(8'h2C, v); check("R10 overflow cleared", {31'b0, v[26]}, 32'd0);

        // R12 disable keeps FIFO, stops capture
        burst(3);
        bus_write(8'h00, 32'd0);
        bus_read(8'h00, v); check("R12 enable off", v, 32'd0);
        burst(4);
        bus_read(8'h20, v); check("R12 count held", v, 32'd1);

        // R2 init flushes
        bus_write(8'h00, 32'd1);
        wait_clk(25);
        bus_read(8'h20, v); check("R2 flushed count", v, 32'd0);
        bus_read(8'h2C, v); check("R2 cleared status", v, 32'd0);

        // R4 prescaler 4
        bus_write(8'h04, make_cfg(MAXW, 2, 4));
        bus_write(8'h34, 32'd1);
        unit_clk = 50;
        burst(3);
        bus_read(8'h24, v); check("R4 prescaled", v, pack_sym(3, MAXW - 3));

        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule